// File: doc/BRIEF.md
# Interrupt Entry Stack Selector

This block turns an accepted interrupt into the fixed entry sequence a CPU core runs before its handler starts. Three kinds of source feed it. A software trap carries a 6-bit interrupt number. A peripheral request carries the 6-bit vector number of the peripheral. A non-maskable pin is active on its falling edge. The block takes a snapshot of the current flag word and program counter. It then pushes the flag word and the PC to the stack on two consecutive cycles, and on the next cycle presents the vector index for the new PC together with the updated flag word.

The stack used for the pushes, and the new value of the stack-select flag U, depend on the source. Peripheral requests and the non-maskable pin always switch to the interrupt stack. A software trap switches only when its number is below 32. Trap numbers 32 and above stay on whatever stack was selected before the trap, so a trap and a peripheral request that share a vector number can reach the same handler on different stacks. The word that is pushed always holds the U value from before the change, so a return restores the caller's stack.

Top module: `int_entry_sel`

## Requirements
- R1: After synchronous reset the outputs `push_vld`, `push_pc`, `sp_sel`, `vec_vld`, `sw_ack` and `per_ack` are all 0.
- R2: An accepted entry pushes the flag word (`push_pc`=0) on the first cycle and the PC (`push_pc`=1) on the cycle after it. On the third cycle `vec_vld`=1 with no push. The first push cycle is the edge after the request is seen while idle.
- R3: A software trap with number 0..31 pushes on the interrupt stack (`sp_sel`=0) and clears U (flag bit 7) in `flg_out`.
- R4: A software trap with number 32..63 pushes on the stack given by the U bit at acceptance (`sp_sel`=U) and leaves U unchanged in `flg_out`.
- R5: A peripheral request pushes on the interrupt stack (`sp_sel`=0) and clears U, whatever the U value was.
- R6: `vec_idx` equals the trap number for a software trap and the vector number for a peripheral request, so equal numbers select the same handler. It is 64 for the non-maskable source.
- R7: The pushed flag word equals `flg_in` as sampled at acceptance, including the original U bit.
- R8: Each falling edge of `nmi_pin_n` (after a two-flop synchronizer) produces exactly one entry on the interrupt stack with U cleared, whatever the enable bit (bit 6) holds. Holding the pin low or raising it produces none.
- R9: When several sources are waiting at the idle point, the non-maskable one is served first, then the software trap, then the peripheral request. `sw_ack` / `per_ack` pulse for one cycle, in the first push cycle, only for the source served.
- R10: All bits of `flg_out` other than U equal the sampled flag word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req | input | 1 | Software trap request, held until `sw_ack` |
| sw_num | input | 6 | Trap number |
| per_req | input | 1 | Peripheral request, held until `per_ack` |
| per_vec | input | 6 | Peripheral vector number |
| nmi_pin_n | input | 1 | Non-maskable pin, falling-edge active |
| flg_in | input | 16 | Current flag word, U at bit 7 |
| pc_in | input | 24 | Current program counter |
| sw_ack | output | 1 | Trap accepted |
| per_ack | output | 1 | Peripheral request accepted |
| push_vld | output | 1 | Stack write this cycle |
| push_pc | output | 1 | 0 = flag word, 1 = PC |
| push_dat | output | 24 | Data to push |
| sp_sel | output | 1 | 0 = interrupt SP, 1 = user SP |
| vec_vld | output | 1 | Vector index and new flags valid |
| vec_idx | output | 7 | Vector table index |
| flg_out | output | 16 | Flag word to load, U updated |

## Verification
The software trap, the peripheral request and a pending non-maskable edge can all be waiting when the sequencer returns to idle. The bench sets this up by starting one trap entry and, during its first push cycle, pulling the pin low and raising a second trap and a peripheral request together. The three entries that follow are judged by their order, their acknowledge pulses, their vector indices and their stack choices. Full sweeps of all 64 trap numbers under both U values, and of all 64 peripheral vectors, check the stack split at 32 arithmetically.

// File: rtl/int_entry_pkg.sv
package int_entry_pkg;
  typedef enum logic [1:0] {SRC_NONE, SRC_NMI, SRC_SW, SRC_PER} src_e;
  typedef enum logic [1:0] {ST_IDLE, ST_PUSH_F, ST_PUSH_PC, ST_VEC} st_e;
endpackage

// File: rtl/nmi_edge.sv
module nmi_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic clr,
  output logic pend
);
  logic [SYNC_STAGES:0] sh;
  logic fall;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[SYNC_STAGES-1:0], pin_n};
  end

  assign fall = sh[SYNC_STAGES] & ~sh[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)       pend <= 1'b0;
    else if (fall) pend <= 1'b1;
    else if (clr)  pend <= 1'b0;
  end

  assert_nmi_latch_R8: assert property (@(posedge clk) disable iff (rst)
    fall |=> pend);
endmodule

// File: rtl/entry_arbiter.sv
module entry_arbiter
  import int_entry_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic idle,
  input  logic nmi_pend,
  input  logic sw_req,
  input  logic per_req,
  output logic g_nmi,
  output logic g_sw,
  output logic g_per,
  output src_e src
);
  always_comb begin
    g_nmi = 1'b0;
    g_sw  = 1'b0;
    g_per = 1'b0;
    src   = SRC_NONE;
    if (idle) begin
      if (nmi_pend) begin
        g_nmi = 1'b1;
        src   = SRC_NMI;
      end else if (sw_req) begin
        g_sw = 1'b1;
        src  = SRC_SW;
      end else if (per_req) begin
        g_per = 1'b1;
        src   = SRC_PER;
      end
    end
  end

  assert_one_grant_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({g_nmi, g_sw, g_per}));
  assert_grant_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (g_nmi || g_sw || g_per) |-> idle);
endmodule

// File: rtl/entry_policy.sv
module entry_policy
  import int_entry_pkg::*;
#(
  parameter int NUM_W       = 6,
  parameter int VEC_W       = NUM_W + 1,
  parameter int NMI_VEC_IDX = 64
) (
  input  src_e             src,
  input  logic [NUM_W-1:0] num,
  input  logic             u_cur,
  output logic             sp_sel,
  output logic             u_new,
  output logic [VEC_W-1:0] vec
);
  localparam int HALF = 1 << (NUM_W - 1);

  always_comb begin
    sp_sel = 1'b0;
    u_new  = 1'b0;
    vec    = VEC_W'(num);
    unique case (src)
      SRC_SW: begin
        if (int'(num) >= HALF) begin
          sp_sel = u_cur;
          u_new  = u_cur;
        end
      end
      SRC_NMI: vec = VEC_W'(NMI_VEC_IDX);
      default: ;
    endcase
  end
endmodule

// File: rtl/int_entry_sel.sv
module int_entry_sel
  import int_entry_pkg::*;
#(
  parameter int NUM_W       = 6,
  parameter int FLG_W       = 16,
  parameter int PC_W        = 24,
  parameter int U_BIT       = 7,
  parameter int NMI_VEC_IDX = 64,
  parameter int SYNC_STAGES = 2,
  localparam int VEC_W      = NUM_W + 1,
  localparam int DAT_W      = (FLG_W > PC_W) ? FLG_W : PC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_req,
  input  logic [NUM_W-1:0] sw_num,
  input  logic             per_req,
  input  logic [NUM_W-1:0] per_vec,
  input  logic             nmi_pin_n,
  input  logic [FLG_W-1:0] flg_in,
  input  logic [PC_W-1:0]  pc_in,
  output logic             sw_ack,
  output logic             per_ack,
  output logic             push_vld,
  output logic             push_pc,
  output logic [DAT_W-1:0] push_dat,
  output logic             sp_sel,
  output logic             vec_vld,
  output logic [VEC_W-1:0] vec_idx,
  output logic [FLG_W-1:0] flg_out
);
  st_e  st;
  logic nmi_pend, g_nmi, g_sw, g_per;
  src_e pick;
  logic [NUM_W-1:0] pick_num;
  logic pol_sp, pol_u;
  logic [VEC_W-1:0] pol_vec;

  logic [PC_W-1:0]  snap_pc;
  logic [FLG_W-1:0] new_flg;
  logic [VEC_W-1:0] vec_hold;
  src_e             cur_src;
  logic [NUM_W-1:0] cur_num;
  logic             snap_u;

  nmi_edge #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
    .clk(clk), .rst(rst), .pin_n(nmi_pin_n), .clr(g_nmi), .pend(nmi_pend)
  );

  entry_arbiter u_arb (
    .clk(clk), .rst(rst), .idle(st == ST_IDLE), .nmi_pend(nmi_pend),
    .sw_req(sw_req), .per_req(per_req),
    .g_nmi(g_nmi), .g_sw(g_sw), .g_per(g_per), .src(pick)
  );

  assign pick_num = g_sw ? sw_num : per_vec;

  entry_policy #(.NUM_W(NUM_W), .VEC_W(VEC_W), .NMI_VEC_IDX(NMI_VEC_IDX)) u_pol (
    .src(pick), .num(pick_num), .u_cur(flg_in[U_BIT]),
    .sp_sel(pol_sp), .u_new(pol_u), .vec(pol_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      sw_ack   <= 1'b0;
      per_ack  <= 1'b0;
      push_vld <= 1'b0;
      push_pc  <= 1'b0;
      push_dat <= '0;
      sp_sel   <= 1'b0;
      vec_vld  <= 1'b0;
      vec_idx  <= '0;
      flg_out  <= '0;
      snap_pc  <= '0;
      new_flg  <= '0;
      vec_hold <= '0;
      cur_src  <= SRC_NONE;
      cur_num  <= '0;
      snap_u   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          vec_vld <= 1'b0;
          if (g_nmi || g_sw || g_per) begin
            st       <= ST_PUSH_F;
            sw_ack   <= g_sw;
            per_ack  <= g_per;
            push_vld <= 1'b1;
            push_pc  <= 1'b0;
            push_dat <= DAT_W'(flg_in);
            sp_sel   <= pol_sp;
            snap_pc  <= pc_in;
            vec_hold <= pol_vec;
            cur_src  <= pick;
            cur_num  <= pick_num;
            snap_u   <= flg_in[U_BIT];
            new_flg  <= flg_in;
            new_flg[U_BIT] <= pol_u;
          end
        end
        ST_PUSH_F: begin
          st       <= ST_PUSH_PC;
          sw_ack   <= 1'b0;
          per_ack  <= 1'b0;
          push_pc  <= 1'b1;
          push_dat <= DAT_W'(snap_pc);
        end
        ST_PUSH_PC: begin
          st       <= ST_VEC;
          push_vld <= 1'b0;
          push_pc  <= 1'b0;
          vec_vld  <= 1'b1;
          vec_idx  <= vec_hold;
          flg_out  <= new_flg;
        end
        default: begin
          st      <= ST_IDLE;
          vec_vld <= 1'b0;
          sp_sel  <= 1'b0;
        end
      endcase
    end
  end

  assert_pc_after_flg_R2: assert property (@(posedge clk) disable iff (rst)
    (push_vld && !push_pc) |=> (push_vld && push_pc));
  assert_vec_after_pc_R2: assert property (@(posedge clk) disable iff (rst)
    (push_vld && push_pc) |=> (vec_vld && !push_vld));
  assert_keep_u_R4: assert property (@(posedge clk) disable iff (rst)
    (vec_vld && cur_src == SRC_SW && cur_num[NUM_W-1]) |-> (flg_out[U_BIT] == snap_u));
  assert_clear_u_R3: assert property (@(posedge clk) disable iff (rst)
    (vec_vld && !(cur_src == SRC_SW && cur_num[NUM_W-1])) |-> !flg_out[U_BIT]);
  assert_isp_push_R5: assert property (@(posedge clk) disable iff (rst)
    (push_vld && cur_src != SRC_SW) |-> !sp_sel);
  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (sw_ack || per_ack) |=> !(sw_ack || per_ack));
  assert_saved_u_R7: assert property (@(posedge clk) disable iff (rst)
    (push_vld && !push_pc) |-> (push_dat[U_BIT] == snap_u));
endmodule

// File: tb/int_entry_sel_bench.sv
module int_entry_sel_bench;
  logic clk = 0;
  logic rst = 1;
  logic sw_req = 0, per_req = 0, nmi_pin_n = 1;
  logic [5:0] sw_num = 0, per_vec = 0;
  logic [15:0] flg_in = 0;
  logic [23:0] pc_in = 0;
  logic sw_ack, per_ack, push_vld, push_pc, sp_sel, vec_vld;
  logic [23:0] push_dat;
  logic [6:0] vec_idx;
  logic [15:0] flg_out;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  int_entry_sel u_int_entry_sel (
    .clk(clk), .rst(rst), .sw_req(sw_req), .sw_num(sw_num), .per_req(per_req),
    .per_vec(per_vec), .nmi_pin_n(nmi_pin_n), .flg_in(flg_in), .pc_in(pc_in),
    .sw_ack(sw_ack), .per_ack(per_ack), .push_vld(push_vld), .push_pc(push_pc),
    .push_dat(push_dat), .sp_sel(sp_sel), .vec_vld(vec_vld), .vec_idx(vec_idx),
    .flg_out(flg_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkv(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  // Waits for an entry and checks its three cycles; arm starts the priority scenario.
  task automatic observe(input string req, input logic [6:0] ev, input logic esp,
                         input logic [15:0] fsaved, input logic [15:0] fnew,
                         input logic [23:0] epc, input logic eack_sw, input logic eack_per,
                         input bit arm);
    int n = 0;
    @(negedge clk);
    while (!push_vld && n < 40) begin
      @(negedge clk);
      n++;
    end
    chkv({req, " entry seen"}, 32'(push_vld), 32'd1);
    chkv({req, " R2 flag push first"}, 32'(push_pc), 32'd0);
    chkv({req, " R7 saved flags"}, 32'(push_dat), 32'(fsaved));
    chkv({req, " stack push1"}, 32'(sp_sel), 32'(esp));
    chkv({req, " R9 sw_ack"}, 32'(sw_ack), 32'(eack_sw));
    chkv({req, " R9 per_ack"}, 32'(per_ack), 32'(eack_per));
    if (sw_ack) sw_req = 0;
    if (per_ack) per_req = 0;
    if (arm) begin
      nmi_pin_n = 0;
      sw_req = 1; sw_num = 6'd3;
      per_req = 1; per_vec = 6'd20;
    end
    @(negedge clk);
    chkv({req, " R2 pc push"}, 32'({push_vld, push_pc}), 32'b11);
    chkv({req, " R2 pc data"}, 32'(push_dat), 32'(epc));
    chkv({req, " stack push2"}, 32'(sp_sel), 32'(esp));
    @(negedge clk);
    chkv({req, " R2 vector cycle"}, 32'({vec_vld, push_vld}), 32'b10);
    chkv({req, " R6 vec_idx"}, 32'(vec_idx), 32'(ev));
    chkv({req, " R10 new flags"}, 32'(flg_out), 32'(fnew));
  endtask

  task automatic quiet(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chkv({req, " no entry"}, 32'({push_vld, vec_vld}), 32'd0);
    end
  endtask

  function automatic logic [15:0] mk_flags(input int seed, input bit u);
    logic [15:0] f = 16'(seed * 517 + 60);
    f[7] = u;
    return f;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chkv("R1 outputs", 32'({push_vld, push_pc, sp_sel, vec_vld, sw_ack, per_ack}), 32'd0);

    // R3 R4 R6 R10: sweep all trap numbers under both U values
    for (int u = 0; u < 2; u++) begin
      for (int n = 0; n < 64; n++) begin
        logic [15:0] f = mk_flags(n + 64 * u, u[0]);
        logic [15:0] fn = f;
        logic esp = (n >= 32) ? u[0] : 1'b0;
        if (n < 32) fn[7] = 1'b0;
        flg_in = f;
        pc_in = 24'(n * 4099 + 7);
        sw_num = 6'(n);
        sw_req = 1;
        observe(n < 32 ? "R3 trap low" : "R4 trap high", 7'(n), esp, f, fn, pc_in, 1'b1, 1'b0, 0);
      end
    end

    // R5 R6: sweep all peripheral vectors with U set
    for (int v = 0; v < 64; v++) begin
      logic [15:0] f = mk_flags(v + 300, 1'b1);
      logic [15:0] fn = f;
      fn[7] = 1'b0;
      flg_in = f;
      pc_in = 24'(v * 77 + 3);
      per_vec = 6'(v);
      per_req = 1;
      observe("R5 peripheral", 7'(v), 1'b0, f, fn, pc_in, 1'b0, 1'b1, 0);
    end

    // R8: falling edge with the enable bit clear still enters on the interrupt stack
    flg_in = 16'h00A5; // U=1, bit 6 = 0
    pc_in = 24'h123456;
    quiet("R8 idle", 3);
    nmi_pin_n = 0;
    observe("R8 nmi edge", 7'd64, 1'b0, 16'h00A5, 16'h0025, 24'h123456, 1'b0, 1'b0, 0);
    quiet("R8 held low", 12);
    nmi_pin_n = 1;
    quiet("R8 rising edge", 12);
    nmi_pin_n = 0;
    observe("R8 second edge", 7'd64, 1'b0, 16'h00A5, 16'h0025, 24'h123456, 1'b0, 1'b0, 0);
    nmi_pin_n = 1;
    quiet("R8 release", 6);

    // R9: nmi, trap and peripheral all waiting when a trap entry ends
    flg_in = 16'h0183;
    pc_in = 24'h00ABCD;
    sw_num = 6'd40;
    sw_req = 1;
    observe("R4 trap before R9", 7'd40, 1'b1, 16'h0183, 16'h0183, 24'h00ABCD, 1'b1, 1'b0, 1);
    observe("R9 nmi first", 7'd64, 1'b0, 16'h0183, 16'h0103, 24'h00ABCD, 1'b0, 1'b0, 0);
    observe("R9 trap second", 7'd3, 1'b0, 16'h0183, 16'h0103, 24'h00ABCD, 1'b1, 1'b0, 0);
    observe("R9 peripheral third", 7'd20, 1'b0, 16'h0183, 16'h0103, 24'h00ABCD, 1'b0, 1'b1, 0);
    quiet("R9 drained", 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule